// File: doc/BRIEF.md
# Way-Partitioned LRU Victim Selector

This block is the replacement controller for one set of a last-level cache that several cores share. Every way of the set belongs to exactly one core. Recency is ranked separately inside each core's group of ways, so "least recently used" is always judged among ways that share an owner. Each core also has a target allocation, which is the number of ways it ought to hold in this set. A partitioning policy outside the block supplies the targets and may change them at any time.

On a miss the block chooses the way to evict. A core that holds fewer ways than its target reclaims a way from a core that holds more than its own target. That way changes owner and becomes the newest way of the requester. A core that is at or above its target, or that finds no over-allocated donor, replaces its own oldest way. On a hit, the hit way becomes the newest way of its owner. The response is registered and appears one cycle after the miss. Tag and data storage belong to the surrounding cache.

Top module: `wpv_victim_sel`

## Requirements
- R1: After reset, way w belongs to core w / (NUM_WAYS/NUM_CORES). Its age is w mod (NUM_WAYS/NUM_CORES), where age 0 means most recently used. With 4 cores and 16 ways, the first misses from cores 0..3 at equal targets of 4 evict ways 3, 7, 11 and 15.
- R2: On a miss, if the requester's way count is at or above its target, or no donor exists, the victim is the requester's own way with the largest age, and rsp_donor_o equals the requester.
- R3: On a miss, if the requester holds fewer ways than its target, the donor is the lowest-numbered other core whose way count exceeds its target. The victim is that donor's oldest way, the way passes to the requester, and rsp_donor_o reports the donor.
- R4: After a miss, the victim way has age 0 in the requester's group. On a local replacement, only the requester's ways younger than the victim age by one. On a takeover, all previous ways of the requester age by one, and the donor's remaining ways keep their ages.
- R5: A hit moves the hit way to age 0 in its owner's group. Only ways of that owner that were younger than it age by one, and no response is produced.
- R6: rsp_valid_o is high for exactly one cycle, in the cycle after each accepted miss (req_valid_i high, req_hit_i low), and is low at all other times.
- R7: A miss from a core that owns no ways and has no eligible donor gives rsp_bypass_o = 1 and changes no ownership or age.
- R8: On a hit, req_core_i is ignored; the recency update uses the owner of req_way_i.
- R9: tgt_i carries the target of core c in bits [c*TW +: TW], with TW = clog2(NUM_WAYS+1), as an unsigned way count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup result present this cycle |
| req_core_i | input | clog2(NUM_CORES) | Requesting core |
| req_hit_i | input | 1 | 1 = hit on req_way_i, 0 = miss |
| req_way_i | input | clog2(NUM_WAYS) | Way that hit (ignored on a miss) |
| tgt_i | input | NUM_CORES*TW | Packed per-core target allocations |
| rsp_valid_o | output | 1 | Victim response strobe |
| rsp_way_o | output | clog2(NUM_WAYS) | Victim way |
| rsp_donor_o | output | clog2(NUM_CORES) | Core that owned the victim before the miss |
| rsp_bypass_o | output | 1 | No way can be given to the requester |

## Verification
The assertions assume that the targets sum to at most NUM_WAYS and that a hit names a valid way index. Under those conditions a requester below its target can only hold up to 15 ways, so an age increment never wraps. The stimulus draws each new target vector so that its sum stays within the way count. The stimulus only changes the targets between requests. It also includes all-to-one allocations that leave a core with no ways at all.

// File: rtl/wpv_pkg.sv
package wpv_pkg;
  localparam int unsigned WPV_CORES = 4;
  localparam int unsigned WPV_WAYS  = 16;

  function automatic int unsigned wpv_clog2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/wpv_occupancy.sv
module wpv_occupancy #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_WAYS  = 16,
  localparam int unsigned CW = wpv_pkg::wpv_clog2(NUM_CORES),
  localparam int unsigned TW = wpv_pkg::wpv_clog2(NUM_WAYS + 1)
) (
  input  logic [NUM_WAYS*CW-1:0]  own_i,
  output logic [NUM_CORES*TW-1:0] cnt_o
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [TW-1:0] sum;
    always_comb begin
      sum = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (own_i[w*CW +: CW] == CW'(c)) sum = sum + TW'(1);
      end
    end
    assign cnt_o[c*TW +: TW] = sum;
  end
endmodule

// File: rtl/wpv_lru_pick.sv
module wpv_lru_pick #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_WAYS  = 16,
  localparam int unsigned CW = wpv_pkg::wpv_clog2(NUM_CORES),
  localparam int unsigned WW = wpv_pkg::wpv_clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS*CW-1:0] own_i,
  input  logic [NUM_WAYS*WW-1:0] age_i,
  input  logic [CW-1:0]          core_i,
  output logic                   found_o,
  output logic [WW-1:0]          way_o
);
  logic [WW-1:0] best;
  always_comb begin
    found_o = 1'b0;
    way_o   = '0;
    best    = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (own_i[w*CW +: CW] == core_i && (!found_o || age_i[w*WW +: WW] > best)) begin
        found_o = 1'b1;
        way_o   = WW'(w);
        best    = age_i[w*WW +: WW];
      end
    end
  end
endmodule

// File: rtl/wpv_donor_pick.sv
module wpv_donor_pick #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_WAYS  = 16,
  localparam int unsigned CW = wpv_pkg::wpv_clog2(NUM_CORES),
  localparam int unsigned TW = wpv_pkg::wpv_clog2(NUM_WAYS + 1)
) (
  input  logic [NUM_CORES*TW-1:0] cnt_i,
  input  logic [NUM_CORES*TW-1:0] tgt_i,
  input  logic [CW-1:0]           req_core_i,
  output logic                    found_o,
  output logic [CW-1:0]           core_o
);
  always_comb begin
    found_o = 1'b0;
    core_o  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (!found_o && CW'(c) != req_core_i &&
          cnt_i[c*TW +: TW] > tgt_i[c*TW +: TW]) begin
        found_o = 1'b1;
        core_o  = CW'(c);
      end
    end
  end
endmodule

// File: rtl/wpv_victim_sel.sv
module wpv_victim_sel #(
  parameter int unsigned NUM_CORES = wpv_pkg::WPV_CORES,
  parameter int unsigned NUM_WAYS  = wpv_pkg::WPV_WAYS,
  localparam int unsigned CW  = wpv_pkg::wpv_clog2(NUM_CORES),
  localparam int unsigned WW  = wpv_pkg::wpv_clog2(NUM_WAYS),
  localparam int unsigned TW  = wpv_pkg::wpv_clog2(NUM_WAYS + 1),
  localparam int unsigned PER = NUM_WAYS / NUM_CORES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [CW-1:0]           req_core_i,
  input  logic                    req_hit_i,
  input  logic [WW-1:0]           req_way_i,
  input  logic [NUM_CORES*TW-1:0] tgt_i,
  output logic                    rsp_valid_o,
  output logic [WW-1:0]           rsp_way_o,
  output logic [CW-1:0]           rsp_donor_o,
  output logic                    rsp_bypass_o
);
  logic [CW-1:0] own_q [NUM_WAYS];
  logic [CW-1:0] own_d [NUM_WAYS];
  logic [WW-1:0] age_q [NUM_WAYS];
  logic [WW-1:0] age_d [NUM_WAYS];
  logic [NUM_WAYS*CW-1:0] own_flat;
  logic [NUM_WAYS*WW-1:0] age_flat;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_flat
    assign own_flat[w*CW +: CW] = own_q[w];
    assign age_flat[w*WW +: WW] = age_q[w];
  end

  logic [NUM_CORES*TW-1:0] cnt;
  logic                    donor_found;
  logic [CW-1:0]           donor_core;
  logic                    self_found, dlru_found;
  logic [WW-1:0]           self_way, dlru_way;

  wpv_occupancy #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_occ (
    .own_i(own_flat), .cnt_o(cnt));

  wpv_donor_pick #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_donor (
    .cnt_i(cnt), .tgt_i(tgt_i), .req_core_i(req_core_i),
    .found_o(donor_found), .core_o(donor_core));

  wpv_lru_pick #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_self_lru (
    .own_i(own_flat), .age_i(age_flat), .core_i(req_core_i),
    .found_o(self_found), .way_o(self_way));

  wpv_lru_pick #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_donor_lru (
    .own_i(own_flat), .age_i(age_flat), .core_i(donor_core),
    .found_o(dlru_found), .way_o(dlru_way));

  logic          below_tgt;
  logic          take_donor;
  logic          miss_acc;
  logic          state_en;
  logic [WW-1:0] rsp_way_d;
  logic [CW-1:0] rsp_donor_d;
  logic          rsp_bypass_d;
  logic [CW-1:0] hit_owner;
  logic [WW-1:0] hit_age;
  logic [WW-1:0] vict_age;

  assign below_tgt  = cnt[req_core_i*TW +: TW] < tgt_i[req_core_i*TW +: TW];
  assign take_donor = below_tgt && donor_found && dlru_found;
  assign miss_acc   = req_valid_i && !req_hit_i;
  assign state_en   = req_valid_i;
  assign hit_owner  = own_q[req_way_i];
  assign hit_age    = age_q[req_way_i];
  assign vict_age   = age_q[self_way];

  // next-state: ownership and recency of the set
  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      own_d[w] = own_q[w];
      age_d[w] = age_q[w];
    end
    rsp_way_d    = '0;
    rsp_donor_d  = req_core_i;
    rsp_bypass_d = 1'b0;
    if (req_valid_i && req_hit_i) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (own_q[w] == hit_owner && age_q[w] < hit_age) age_d[w] = age_q[w] + WW'(1);
      end
      age_d[req_way_i] = '0;
    end else if (miss_acc) begin
      if (take_donor) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (own_q[w] == req_core_i) age_d[w] = age_q[w] + WW'(1);
        end
        own_d[dlru_way] = req_core_i;
        age_d[dlru_way] = '0;
        rsp_way_d       = dlru_way;
        rsp_donor_d     = donor_core;
      end else if (self_found) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (own_q[w] == req_core_i && age_q[w] < vict_age) age_d[w] = age_q[w] + WW'(1);
        end
        age_d[self_way] = '0;
        rsp_way_d       = self_way;
      end else begin
        rsp_bypass_d = 1'b1;
      end
    end
  end

  // state registers, enabled by any accepted request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        own_q[w] <= CW'(w / PER);
        age_q[w] <= WW'(w % PER);
      end
    end else if (state_en) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        own_q[w] <= own_d[w];
        age_q[w] <= age_d[w];
      end
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o  <= 1'b0;
      rsp_way_o    <= '0;
      rsp_donor_o  <= '0;
      rsp_bypass_o <= 1'b0;
    end else begin
      rsp_valid_o <= miss_acc;
      if (miss_acc) begin
        rsp_way_o    <= rsp_way_d;
        rsp_donor_o  <= rsp_donor_d;
        rsp_bypass_o <= rsp_bypass_d;
      end
    end
  end

  // ---------------- assertions ----------------
  a_r6_rsp_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(req_valid_i && !req_hit_i));

  a_r6_miss_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_hit_i) |=> rsp_valid_o);

  a_r5_hit_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_hit_i) |=> !rsp_valid_o);

  a_r4_victim_owned_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_bypass_o) |->
      (own_q[rsp_way_o] == $past(req_core_i) && age_q[rsp_way_o] == '0));

  a_r5_hit_way_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_hit_i) |=> age_q[$past(req_way_i)] == '0);

  // R1..R5: each core's ages form the set 0..count-1
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic [NUM_WAYS:0] amask;
    logic [NUM_WAYS:0] full;
    always_comb begin
      amask = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (own_q[w] == CW'(c)) amask[age_q[w]] = 1'b1;
      end
      full = ((NUM_WAYS+1)'(1) << cnt[c*TW +: TW]) - (NUM_WAYS+1)'(1);
    end
    a_r1_stack_dense: assert property (@(posedge clk) disable iff (!rst_n)
      amask == full);
  end
endmodule

// File: tb/test_wpv_victim_sel.sv
module test_wpv_victim_sel;
  localparam int NC = 4;
  localparam int NW = 16;
  localparam int CW = 2;
  localparam int WW = 4;
  localparam int TW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid_i, req_hit_i;
  logic [CW-1:0] req_core_i;
  logic [WW-1:0] req_way_i;
  logic [NC*TW-1:0] tgt_i;
  logic rsp_valid_o, rsp_bypass_o;
  logic [WW-1:0] rsp_way_o;
  logic [CW-1:0] rsp_donor_o;

  always #2 clk = ~clk;

  wpv_victim_sel i_wpv_victim_sel (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_core_i(req_core_i),
    .req_hit_i(req_hit_i), .req_way_i(req_way_i), .tgt_i(tgt_i),
    .rsp_valid_o(rsp_valid_o), .rsp_way_o(rsp_way_o),
    .rsp_donor_o(rsp_donor_o), .rsp_bypass_o(rsp_bypass_o));

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  int m_own [NW];
  int m_age [NW];
  int m_tgt [NC];

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_tgt(input int t0, input int t1, input int t2, input int t3);
    m_tgt[0] = t0; m_tgt[1] = t1; m_tgt[2] = t2; m_tgt[3] = t3;
    for (int c = 0; c < NC; c++) tgt_i[c*TW +: TW] = TW'(m_tgt[c]);  // R9 packing
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid_i = 0; req_hit_i = 0; req_core_i = 0; req_way_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int w = 0; w < NW; w++) begin
      m_own[w] = w / (NW / NC);
      m_age[w] = w % (NW / NC);
    end
    @(negedge clk);
  endtask

  function automatic int lru_of(input int c);
    int v = -1;
    for (int w = 0; w < NW; w++)
      if (m_own[w] == c && (v < 0 || m_age[w] > m_age[v])) v = w;
    return v;
  endfunction

  // issue one request at a negedge; checks the response at the next negedge
  task automatic op(input int c, input bit h, input int way, input string tag,
                    output int got_way, output int got_don, output int got_byp);
    int cnt [NC];
    int d, v, a, e_don, e_byp;
    for (int k = 0; k < NC; k++) cnt[k] = 0;
    for (int w = 0; w < NW; w++) cnt[m_own[w]]++;
    e_byp = 0; v = 0; e_don = c;
    if (h) begin
      a = m_age[way];
      for (int w = 0; w < NW; w++)
        if (m_own[w] == m_own[way] && m_age[w] < a) m_age[w]++;
      m_age[way] = 0;
    end else begin
      d = -1;
      if (cnt[c] < m_tgt[c])
        for (int k = 0; k < NC; k++)
          if (d < 0 && k != c && cnt[k] > m_tgt[k]) d = k;
      if (d >= 0) begin
        v = lru_of(d);
        for (int w = 0; w < NW; w++) if (m_own[w] == c) m_age[w]++;
        m_own[v] = c; m_age[v] = 0; e_don = d;
      end else if (cnt[c] > 0) begin
        v = lru_of(c); a = m_age[v];
        for (int w = 0; w < NW; w++) if (m_own[w] == c && m_age[w] < a) m_age[w]++;
        m_age[v] = 0;
      end else e_byp = 1;
    end
    req_valid_i = 1; req_core_i = CW'(c); req_hit_i = h; req_way_i = WW'(way);
    @(negedge clk);
    req_valid_i = 0;
    got_way = rsp_way_o; got_don = rsp_donor_o; got_byp = rsp_bypass_o;
    if (h) check({tag, " R5 no rsp on hit"}, rsp_valid_o, 0);
    else begin
      check({tag, " R6 rsp valid"}, rsp_valid_o, 1);
      check({tag, " R7 bypass"}, rsp_bypass_o, e_byp);
      if (!e_byp) begin
        check({tag, " R2/R3 way"}, rsp_way_o, v);
        check({tag, " R3 donor"}, rsp_donor_o, e_don);
      end
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!finished && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected finish", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int gw, gd, gb;
    set_tgt(4, 4, 4, 4);
    do_reset();
    check("R6 idle after reset", rsp_valid_o, 0);
    // R1: reset layout gives these LRU ways
    for (int c = 0; c < NC; c++) begin
      op(c, 0, 0, "R1", gw, gd, gb);
      check("R1 reset LRU way", gw, c * 4 + 3);
    end
    op(0, 0, 0, "R4 second miss", gw, gd, gb);
    check("R4 next LRU", gw, 2);

    // R5/R8: hit on core0 way issued by core2
    do_reset();
    op(2, 1, 1, "R8 foreign hit", gw, gd, gb);
    check("R6 hit leaves strobe low", rsp_valid_o, 0);
    for (int i = 0; i < 3; i++) op(0, 0, 0, "R5 order after hit", gw, gd, gb);
    check("R5 third victim", gw, 0);

    // R3: takeover, then R2 at target
    do_reset();
    set_tgt(6, 2, 4, 4);
    op(0, 0, 0, "R3 take1", gw, gd, gb);
    check("R3 way", gw, 7); check("R3 donor id", gd, 1);
    op(0, 0, 0, "R3 take2", gw, gd, gb);
    check("R3 way2", gw, 6);
    op(0, 0, 0, "R2 at target", gw, gd, gb);
    check("R2 own LRU", gw, 3); check("R2 donor self", gd, 0);

    // R7: core3 stripped, then refilled from core2
    do_reset();
    set_tgt(8, 4, 4, 0);
    for (int i = 0; i < 4; i++) op(0, 0, 0, "R3 strip", gw, gd, gb);
    op(3, 0, 0, "R7 empty", gw, gd, gb);
    check("R7 bypass flag", gb, 1);
    op(3, 0, 0, "R7 state kept", gw, gd, gb);
    set_tgt(8, 4, 3, 1);
    op(3, 0, 0, "R3 refill", gw, gd, gb);
    check("R3 refill way", gw, 11); check("R3 refill donor", gd, 2);

    // sweep: random targets and traffic against the model
    do_reset();
    for (int seg = 0; seg < 60; seg++) begin
      int t0, t1, t2, t3;
      t0 = $urandom % 9; t1 = $urandom % (17 - t0);
      t2 = $urandom % (17 - t0 - t1); t3 = (seg % 3 == 0) ? 16 - t0 - t1 - t2 : 0;
      set_tgt(t0, t1, t2, t3);
      for (int i = 0; i < 50; i++) begin
        int c = $urandom % NC;
        bit h = ($urandom % 3) == 0;
        op(c, h, $urandom % NW, "R4 sweep", gw, gd, gb);
      end
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule